// File: doc/BRIEF.md
# Time-Delay Modulation Transmitter

The block turns a stream of 6-bit sample codes into a time offset between two serial bit streams. An internal maximal-length pseudorandom generator produces the reference stream. That stream also feeds a 64-stage delay line. The delay line is clocked on the falling edge of the system clock, so it never changes on the same edge as the generator. One stage of the delay line, chosen by the current sample code, is inverted and sent out as the delayed stream. A receiver that compares the two streams over one frame recovers the code from the offset between them.

Sample codes are taken once per eight-cycle frame. A 3-bit frame counter marks the last cycle of each frame with a one-cycle pulse. At the rising edge that ends that cycle, the code on the input is captured. It then steers the tap selector for the whole of the following frame. The selector works in two levels: the low four code bits pick one tap inside each group of sixteen, and the high two bits pick one of the four group candidates.

Top module: `tdm_tx`

## Requirements
- R1: The reference output is bit 7 of an 8-bit state that is loaded with 0x01 during reset. On each rising edge out of reset, the state shifts left and takes as its new bit 0 the XOR of its bits 7, 5, 4 and 3. The state is never all zeros.
- R2: During reset the delay line holds all zeros. In the first frame after reset, any tap whose history reaches back before reset reads zero, so the delayed output is 1.
- R3: Cycles are numbered from 0, starting with the first cycle after reset is released. After the falling edge of cycle t, with latched code c and t >= c, the delayed output equals the inverse of the reference output of cycle t-c. Code 0 gives the inverse of the current cycle's reference.
- R4: The frame pulse is high for exactly one cycle in every eight, in the cycles where t mod 8 = 7. It is low during reset.
- R5: The code input is captured only at the rising edge that ends a frame-pulse cycle. It is held for the next eight cycles. Code input changes in any other cycle have no effect on the delayed output.
- R6: The latched code is 0 during reset and throughout frame 0 (cycles 0 to 7).
- R7: Tap selection uses code bits [3:0] to pick the tap within a group of 16, and bits [5:4] to pick the group. The selected tap index equals the code value, including at group edges (15/16, 47/48) and at the ends of the range (0, 63).
- R8: The reference stream is periodic with a period of 255 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the generator uses the rising edge, the delay line the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_code | input | 6 | Sample code, captured at the end of each frame |
| ref_bit | output | 1 | Reference pseudorandom bit stream |
| dly_bit | output | 1 | Inverted reference, delayed by the latched code in clock periods |
| frame_mark | output | 1 | One-cycle pulse in the last cycle of each 8-cycle frame |

## Verification
On every cycle, the embedded assertions check the following: the generator never reaches the all-zero state, the frame pulse never lasts two cycles, and the latched code moves only after a frame pulse and then takes the input value. They also check the zero-delay and one-cycle-delay cases of the output relation. Only the bench scenarios can show the general delay relation for every code. This includes the group-boundary codes, the empty delay line right after reset, and the immunity to code changes in the middle of a frame. The bench also checks the exact generator sequence and its 255-cycle period.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int CODE_W    = 6;
    localparam int GRP_W     = 4;
    localparam int LFSR_W    = 8;
    localparam int FRAME_W   = 3;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 8'hB8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;

    typedef struct packed {
        logic [FRAME_W-1:0] phase;
        logic               last;
    } frame_t;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s,
                                                    input logic [LFSR_W-1:0] m);
        return {s[LFSR_W-2:0], ^(s & m)};
    endfunction
endpackage

// File: rtl/tdm_prbs_gen.sv
module tdm_prbs_gen #(
    parameter int              W    = tdm_pkg::LFSR_W,
    parameter logic [W-1:0]    MASK = tdm_pkg::LFSR_MASK,
    parameter logic [W-1:0]    SEED = tdm_pkg::LFSR_SEED
) (
    input  logic clk,
    input  logic rst,
    output logic bit_out
);
    logic [W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= tdm_pkg::lfsr_next(state, MASK);
    end

    assign bit_out = state[W-1];

    // R1: maximal-length state never collapses to zero
    a_r1_never_zero: assert property (@(posedge clk) disable iff (rst)
        state != '0);
endmodule

// File: rtl/tdm_delay_line.sv
module tdm_delay_line #(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);
    logic [DEPTH-1:0] line_q;

    // falling-edge clocking keeps the line out of phase with the generator
    always_ff @(negedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= {line_q[DEPTH-2:0], din};
    end

    assign taps = line_q;
endmodule

// File: rtl/tdm_tap_select.sv
module tdm_tap_select #(
    parameter int CODE_W = tdm_pkg::CODE_W,
    parameter int GRP_W  = tdm_pkg::GRP_W
) (
    input  logic [2**CODE_W-1:0] taps,
    input  logic [CODE_W-1:0]    code,
    output logic                 sel
);
    localparam int GSZ  = 2**GRP_W;
    localparam int NGRP = 2**(CODE_W-GRP_W);

    logic [NGRP-1:0] cand;
    logic [GRP_W-1:0] lo;
    logic [CODE_W-GRP_W-1:0] hi;

    assign lo = code[GRP_W-1:0];
    assign hi = code[CODE_W-1:GRP_W];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GSZ-1:0] slice;
        assign slice   = taps[g*GSZ +: GSZ];
        assign cand[g] = slice[lo];
    end

    assign sel = cand[hi];
endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl #(
    parameter int FRAME_W = tdm_pkg::FRAME_W,
    parameter int CODE_W  = tdm_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q,
    output logic              frame_last
);
    localparam logic [FRAME_W-1:0] LAST = FRAME_W'(2**FRAME_W - 1);

    tdm_pkg::frame_t fr;

    always_ff @(posedge clk) begin
        if (rst) fr.phase <= '0;
        else     fr.phase <= fr.phase + 1'b1;
    end

    assign fr.last = (fr.phase == LAST);

    always_ff @(posedge clk) begin
        if (rst)          code_q <= '0;
        else if (fr.last) code_q <= code_in;
    end

    assign frame_last = fr.last;

    // R4: frame pulse lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> !frame_last);
    // R5: code is held outside frame ends
    a_r5_code_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(code_q));
    // R5: code loads from the input at a frame end
    a_r5_code_load: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> code_q == $past(code_in));
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
    parameter int CODE_W  = tdm_pkg::CODE_W,
    parameter int GRP_W   = tdm_pkg::GRP_W,
    parameter int FRAME_W = tdm_pkg::FRAME_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] sample_code,
    output logic              ref_bit,
    output logic              dly_bit,
    output logic              frame_mark
);
    localparam int DEPTH = 2**CODE_W;

    logic [DEPTH-1:0]  taps;
    logic [CODE_W-1:0] code_q;
    logic              tap_sel;

    tdm_prbs_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .bit_out (ref_bit)
    );

    tdm_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk  (clk),
        .rst  (rst),
        .din  (ref_bit),
        .taps (taps)
    );

    tdm_frame_ctrl #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .code_in    (sample_code),
        .code_q     (code_q),
        .frame_last (frame_mark)
    );

    tdm_tap_select #(.CODE_W(CODE_W), .GRP_W(GRP_W)) u_sel (
        .taps (taps),
        .code (code_q),
        .sel  (tap_sel)
    );

    assign dly_bit = ~tap_sel;

    // R3: code 0 sends the inverted reference of the same cycle
    a_r3_zero_delay: assert property (@(posedge clk) disable iff (rst)
        (code_q == '0) |-> dly_bit == ~ref_bit);
    // R7: code 1 sends the inverted reference of the previous cycle
    a_r7_unit_delay: assert property (@(posedge clk) disable iff (rst)
        (code_q == CODE_W'(1)) |-> dly_bit == ~$past(ref_bit));
endmodule

// File: tb/tdm_tx_bench.sv
module tdm_tx_bench;
    localparam int NFR  = 256;
    localparam int NCYC = NFR * 8;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] sample_code;
    logic       ref_bit, dly_bit, frame_mark;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit hist [0:NCYC-1];
    logic [5:0] fc [0:NFR];
    logic [7:0] m;

    always #4 clk = ~clk;

    tdm_tx u_tdm_tx (
        .clk         (clk),
        .rst         (rst),
        .sample_code (sample_code),
        .ref_bit     (ref_bit),
        .dly_bit     (dly_bit),
        .frame_mark  (frame_mark)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // directed frame codes: extremes and group edges (R7), then random
        fc[0] = 6'd0;  fc[1] = 6'd63; fc[2] = 6'd15; fc[3] = 6'd16;
        fc[4] = 6'd47; fc[5] = 6'd48; fc[6] = 6'd0;  fc[7] = 6'd1;
        fc[8] = 6'd32; fc[9] = 6'd63;
        for (int f = 10; f <= NFR; f++) fc[f] = 6'($urandom);

        rst = 1'b1;
        sample_code = 6'd0;
        repeat (3) @(posedge clk);
        #6;
        // R1 R2 R4 R6 reset state
        check(ref_bit == 1'b0, "R1 reset ref", int'(ref_bit), 0);
        check(frame_mark == 1'b0, "R4 reset frame", int'(frame_mark), 0);
        check(dly_bit == 1'b1, "R2 R6 reset dly", int'(dly_bit), 1);
        @(posedge clk);
        #2;
        rst = 1'b0;
        m = 8'h01;

        for (int t = 0; t < NCYC; t++) begin
            // code changes inside a frame must be ignored (R5)
            if (t % 8 == 7) sample_code = fc[t/8 + 1];
            else            sample_code = 6'($urandom);
            #4;
            hist[t] = ref_bit;
            check(ref_bit == m[7], "R1 ref sequence", int'(ref_bit), int'(m[7]));
            check(frame_mark == (t % 8 == 7), "R4 frame pulse",
                  int'(frame_mark), int'(t % 8 == 7));
            begin
                int c;
                bit ex;
                c  = int'(fc[t/8]);
                ex = (t >= c) ? ~hist[t-c] : 1'b1;
                if (t < 8)
                    check(dly_bit == ex, "R6 R2 first frame", int'(dly_bit), int'(ex));
                else
                    check(dly_bit == ex, "R3 R5 R7 delay", int'(dly_bit), int'(ex));
            end
            if (t >= 255)
                check(hist[t] == hist[t-255], "R8 period", int'(hist[t]), int'(hist[t-255]));
            m = model_step(m);
            @(posedge clk);
            #2;
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule